// File: doc/BRIEF.md
# Frame Sync Format Detector and Translator

This block watches an 8 kHz frame synchronisation input that can arrive in one of two shapes. The first shape (called format A here) sits high between frames and drops low for a short time across the frame boundary. The second shape (format B) sits low between frames and goes high at the start of timeslot 5. The block finds the shape from the idle level of the input. It then runs the frame timing counters (timeslot, bit and clock phase) in step with the input. It also produces an output frame pulse in the other shape. Format A input gives a format B output five channels later. Format B input gives a format A output 27 channels later.

Each clock is one half of a bit period. A channel is 16 clocks and a frame is 512 clocks. All counters, the format flag, the valid flag and the output pulse are registered. They change only on the rising clock edge.

Top module: `fsync_xlate`

## Requirements
- R1: While reset is high, and on the first clock after it, the frame counter is 0 (timeslot 0, bit 0, phase 0). The format flag is 0 (format A), the valid flag is 0 and the output pulse is 0.
- R2: The idle level becomes known only when five consecutive input samples hold the same level. Before that, no input edge touches the counters, so the counter keeps running from reset. This includes the case of a low pulse after only four high samples.
- R3: Once the idle level is known to be high, a falling input edge is taken as a format A pulse. The clock after the first low sample is timeslot 0, bit 0, phase 0, and the format flag reads 0.
- R4: Once the idle level is known to be low, a rising input edge is taken as a format B pulse. The clock after the first high sample is timeslot 5, bit 0, phase 1, and the format flag reads 1.
- R5: The frame counter advances by one every clock. Timeslot is counter bits [8:4], bit is bits [3:1] and phase is bit [0]. The counter wraps from 511 (timeslot 31) to 0.
- R6: With a format A input and valid high, the output is high for the two clocks at counter values 80 and 81 (start of timeslot 5) and low otherwise.
- R7: With a format B input and valid high, the output is low for the two clocks at counter values 511 and 0 (across the frame boundary) and high otherwise.
- R8: Valid goes high on the second input pulse of the same format. While valid is low, the output holds its idle level: low for a format A input, high for a format B input.
- R9: When an input pulse of the other format arrives, the format flag switches to that format, the counters reload, and valid drops to 0 until one more pulse of that format is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock, two clocks per bit |
| rst | input | 1 | Synchronous reset, active high |
| fp_in | input | 1 | Frame sync input, format A or format B |
| fmt_b_o | output | 1 | Detected input format: 0 = format A, 1 = format B |
| valid_o | output | 1 | High once a full frame has been seen in the current format |
| ts_o | output | 5 | Timeslot counter |
| bit_o | output | 3 | Bit counter within the timeslot |
| phase_o | output | 1 | Clock phase within the bit |
| fp_out | output | 1 | Frame sync output in the other format |

## Verification
The bench tests the detection window at its edge:
- It sends a pulse after exactly four high samples, which a design with a short window would lock onto and use to reload its counter.
- It sends a pulse after five high samples, which a design with a long window would ignore.

It walks both formats through several frames and samples the counters and the output at the timeslot 5 edges and at the frame wrap. A wrong preset, or an off-by-one clock in the output decode, shows up there as a pulse one clock off.

It then switches the input from format A to format B without a reset. A design that kept the old valid state, or kept the old counter phase, would give a wrong pulse in the first frame after the switch.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
  typedef enum logic {FMT_A = 1'b0, FMT_B = 1'b1} fsx_fmt_e;
endpackage

// File: rtl/fsx_idle_det.sv
module fsx_idle_det #(
  parameter int DET_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic fp_in,
  output logic ev_o,
  output logic ev_fmt_b_o
);
  localparam int FW = $clog2(DET_LEN) + 1;

  logic [DET_LEN-2:0] hist_q;
  logic [FW-1:0]      fill_q;
  logic               known_q;
  logic               idle_hi_q;
  logic               prev_q;
  logic [DET_LEN-1:0] win;
  logic               full;

  assign win  = {hist_q, fp_in};
  assign full = (fill_q == FW'(DET_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q    <= '0;
      fill_q    <= '0;
      known_q   <= 1'b0;
      idle_hi_q <= 1'b0;
      prev_q    <= 1'b0;
    end else begin
      hist_q <= win[DET_LEN-2:0];
      prev_q <= fp_in;
      if (!full) fill_q <= fill_q + 1'b1;
      if (full && (&win)) begin
        known_q   <= 1'b1;
        idle_hi_q <= 1'b1;
      end else if (full && !(|win)) begin
        known_q   <= 1'b1;
        idle_hi_q <= 1'b0;
      end
    end
  end

  // A pulse edge is the departure from the known idle level
  assign ev_o       = known_q & (idle_hi_q ? (prev_q & ~fp_in) : (~prev_q & fp_in));
  assign ev_fmt_b_o = ~idle_hi_q;

  assert_idle_learned_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(known_q) |-> ($past(fp_in) == idle_hi_q));
endmodule

// File: rtl/fsx_frame_cnt.sv
module fsx_frame_cnt #(
  parameter int FRAME_CLKS = 512,
  localparam int CW = $clog2(FRAME_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] nxt_o
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign nxt_o = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else           cnt_q <= nxt_o;
  end

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt_q == (($past(cnt_q) == LAST) ? '0 : $past(cnt_q) + 1'b1)));
  assert_cnt_load_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/fsx_pulse_out.sv
module fsx_pulse_out #(
  parameter int FRAME_CLKS = 512,
  parameter int OFF_CLKS   = 80,
  parameter int PULSE_W    = 2,
  localparam int CW = $clog2(FRAME_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] nxt,
  input  logic          valid,
  input  logic          fmt_b,
  output logic          fp_out
);
  localparam logic [CW-1:0] B_LO = CW'(OFF_CLKS);
  localparam logic [CW-1:0] B_HI = CW'(OFF_CLKS + PULSE_W - 1);
  localparam logic [CW-1:0] A_LO = CW'(FRAME_CLKS - PULSE_W / 2);
  localparam logic [CW-1:0] A_HI = CW'(PULSE_W - PULSE_W / 2 - 1);

  logic a_act, b_act;

  always_comb begin
    b_act = (nxt >= B_LO) && (nxt <= B_HI);
    a_act = (nxt >= A_LO) || (nxt <= A_HI);
  end

  // Decode the count of the coming clock so the register lands on it
  always_ff @(posedge clk) begin
    if (rst)        fp_out <= 1'b0;
    else if (valid) fp_out <= fmt_b ? ~a_act : b_act;
    else            fp_out <= fmt_b;
  end

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (fp_out == $past(fmt_b)));
endmodule

// File: rtl/fsync_xlate.sv
module fsync_xlate #(
  parameter int CH_PER_FRAME = 32,
  parameter int BITS_PER_CH  = 8,
  parameter int CLKS_PER_BIT = 2,
  parameter int OFFSET_CH    = 5,
  parameter int DET_LEN      = 5,
  parameter int PULSE_W      = 2,
  localparam int TSW = $clog2(CH_PER_FRAME),
  localparam int BW  = $clog2(BITS_PER_CH),
  localparam int PHW = $clog2(CLKS_PER_BIT)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fp_in,
  output logic           fmt_b_o,
  output logic           valid_o,
  output logic [TSW-1:0] ts_o,
  output logic [BW-1:0]  bit_o,
  output logic [PHW-1:0] phase_o,
  output logic           fp_out
);
  import fsx_pkg::*;

  localparam int CLKS_PER_CH = BITS_PER_CH * CLKS_PER_BIT;
  localparam int FRAME_CLKS  = CH_PER_FRAME * CLKS_PER_CH;
  localparam int CW          = $clog2(FRAME_CLKS);
  localparam int OFF_CLKS    = OFFSET_CH * CLKS_PER_CH;
  localparam logic [CW-1:0] LOAD_A = '0;
  localparam logic [CW-1:0] LOAD_B = CW'(OFF_CLKS + 1);

  logic          ev, ev_fmt_b;
  logic [CW-1:0] cnt, nxt;
  fsx_fmt_e      fmt_q;
  logic          synced_q, valid_q;
  logic          fmt_b;

  fsx_idle_det #(.DET_LEN(DET_LEN)) u_det (
    .clk(clk), .rst(rst), .fp_in(fp_in), .ev_o(ev), .ev_fmt_b_o(ev_fmt_b)
  );

  fsx_frame_cnt #(.FRAME_CLKS(FRAME_CLKS)) u_cnt (
    .clk(clk), .rst(rst), .load(ev), .load_val(ev_fmt_b ? LOAD_B : LOAD_A),
    .cnt_o(cnt), .nxt_o(nxt)
  );

  assign fmt_b = (fmt_q == FMT_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q    <= FMT_A;
      synced_q <= 1'b0;
      valid_q  <= 1'b0;
    end else if (ev) begin
      if (!synced_q || (ev_fmt_b != fmt_b)) begin
        synced_q <= 1'b1;
        valid_q  <= 1'b0;
        fmt_q    <= ev_fmt_b ? FMT_B : FMT_A;
      end else begin
        valid_q  <= 1'b1;
      end
    end
  end

  fsx_pulse_out #(.FRAME_CLKS(FRAME_CLKS), .OFF_CLKS(OFF_CLKS), .PULSE_W(PULSE_W)) u_out (
    .clk(clk), .rst(rst), .nxt(nxt), .valid(valid_q), .fmt_b(fmt_b), .fp_out(fp_out)
  );

  assign fmt_b_o = fmt_b;
  assign valid_o = valid_q;
  assign ts_o    = cnt[CW-1 -: TSW];
  assign bit_o   = cnt[PHW +: BW];
  assign phase_o = cnt[PHW-1:0];

  assert_fmt_switch_R9: assert property (@(posedge clk) disable iff (rst)
    (ev && synced_q && (ev_fmt_b != fmt_b)) |=> (!valid_q && (fmt_b == $past(ev_fmt_b))));
  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(ev));
endmodule

// File: tb/fsync_xlate_tb_top.sv
module fsync_xlate_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fp_in = 1'b1;
  logic       fmt_b_o, valid_o, fp_out;
  logic [4:0] ts_o;
  logic [2:0] bit_o;
  logic [0:0] phase_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  // columns: frame clock index, expected timeslot
  localparam int NV = 12;
  localparam int VEC [NV][2] = '{
    '{0, 0}, '{1, 0}, '{15, 0}, '{16, 1}, '{79, 4}, '{80, 5},
    '{81, 5}, '{82, 5}, '{255, 15}, '{496, 31}, '{510, 31}, '{511, 31}};

  always #5 clk = ~clk;

  fsync_xlate dut_i (
    .clk(clk), .rst(rst), .fp_in(fp_in), .fmt_b_o(fmt_b_o), .valid_o(valid_o),
    .ts_o(ts_o), .bit_o(bit_o), .phase_o(phase_o), .fp_out(fp_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt_now();
    return {ts_o, bit_o, phase_o};
  endfunction

  task automatic run_mode(input bit in_b, input int nfr, input bit switching);
    int np = 0;
    int pc = in_b ? 80 : 511;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      fp_in = in_b ? 1'b0 : 1'b1;
    end
    for (int k = 0; k < nfr * 512; k++) begin
      int  c;
      bit  act;
      c = (pc + 2 + k) % 512;
      @(negedge clk);
      if (np >= 1) begin
        for (int v = 0; v < NV; v++) begin
          if (VEC[v][0] == c) begin
            int  exp_c;
            bit  exp_o;
            exp_c = VEC[v][1] * 16 + ((c >> 1) & 7) * 2 + (c & 1);
            chk(cnt_now() == exp_c && ts_o == 5'(VEC[v][1]),
                in_b ? "R4 R5 counter" : "R3 R5 counter", cnt_now(), exp_c);
            chk(fmt_b_o == in_b, switching ? "R9 format" : "R3 format", fmt_b_o, in_b);
            chk(valid_o == (np >= 2), switching ? "R9 valid" : "R8 valid", valid_o, np >= 2);
            if (!(np == 1 && c == (pc + 1) % 512)) begin
              if (np >= 2) exp_o = in_b ? !(c == 511 || c == 0) : (c == 80 || c == 81);
              else         exp_o = in_b;
              chk(fp_out == exp_o, np >= 2 ? (in_b ? "R7 output" : "R6 output") : "R8 idle",
                  fp_out, exp_o);
            end
          end
        end
      end
      act   = (c == pc) || (c == (pc + 1) % 512);
      fp_in = in_b ? act : ~act;
      if (c == pc) np++;
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      finish_up();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cnt_now() == 0, "R1 counter", cnt_now(), 0);
    chk(fmt_b_o == 1'b0, "R1 format", fmt_b_o, 0);
    chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
    chk(fp_out == 1'b0, "R1 output", fp_out, 0);

    // R2: four idle samples then a low pulse is ignored
    rst = 1'b0;
    for (int i = 1; i <= 9; i++) begin
      if (i > 1) @(negedge clk);
      fp_in = (i == 5 || i == 6) ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    chk(cnt_now() == 9, "R2 short idle ignored", cnt_now(), 9);

    // R2 / R3: five idle samples then a low pulse reloads to 0
    rst = 1'b1;
    fp_in = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      if (i > 1) @(negedge clk);
      fp_in = (i == 6) ? 1'b0 : 1'b1;
    end
    @(negedge clk);
    chk(cnt_now() == 0, "R2 R3 five idle then pulse", cnt_now(), 0);
    fp_in = 1'b1;

    // Format A frames from a fresh reset
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run_mode(1'b0, 4, 1'b0);

    // Switch to format B without reset
    run_mode(1'b1, 4, 1'b1);

    done = 1'b1;
    finish_up();
  end
endmodule